// File: doc/BRIEF.md
# Gated Six-Pair Clock Output Enable Controller

This block decides, for each of six differential clock output pairs, whether the pair carries the shared output clock or sits in a parked state. Three conditions must all hold for a pair to run: the upstream PLL reports lock, a per-pair register enable is set, and the pair's external enable pin matches the sense chosen by a per-pair polarity bit. When any of these fails, the pair parks in the state selected by a 2-bit stop code. That state drives both lines low, drives one line high and the other low, or flags both lines for high impedance.

The enable pins are asynchronous. Each pin passes through a two-stage synchronizer clocked by the output clock. The run decision for each pair is then registered on the falling edge of that clock. Gating therefore changes only while the clock is low, and a started or stopped output never shows a shortened high pulse. The analog driver behind each pair takes the true level, the complement level and the high-impedance flag from this block.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: With its polarity bit at 0, a pair is enabled while its enable pin is low and disabled while the pin is high. Bit i of every per-pair bus belongs to pair i, for i from 0 to 5.
- R2: With its polarity bit at 1, a pair is enabled while its enable pin is high and disabled while the pin is low.
- R3: A register enable bit of 0 disables its pair whatever the pin and the polarity bit say.
- R4: While the PLL lock input is low, every pair is disabled.
- R5: A running pair drives the true line equal to the clock and the complement line equal to its inverse, with the high-impedance flag at 0.
- R6: A disabled pair follows the stop code. Code 00 drives true 0, complement 0 and flag 0. Code 01 sets the flag to 1 with both levels at 0. Code 10 drives true 1 and complement 0. Code 11 drives true 0 and complement 1. The flag is 0 for codes 00, 10 and 11.
- R7: After an enable pin changes to its enabling level, the pair's first clock high phase on the true line appears within 1 to 3 rising clock edges.
- R8: After an enable pin changes to its disabling level, the pair is parked within 1 to 3 rising clock edges.
- R9: Gating switches only during the clock's low phase. With stop codes 00 or 01, the true line never rises while the clock is low.
- R10: While reset is asserted, every pair is disabled and shows the stop-code state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_out_i | input | 1 | Shared output clock; also clocks the control logic |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pll_locked_i | input | 1 | PLL lock indication, synchronous to clk_out_i |
| oe_pin_i | input | 6 | Asynchronous per-pair enable pins |
| oe_pol_i | input | 6 | Per-pair pin sense: 0 enables on low, 1 enables on high |
| oe_reg_i | input | 6 | Per-pair register enable; 0 forces the pair off |
| stop_code_i | input | 2 | Parked-state code shared by all pairs |
| dif_true_o | output | 6 | True line level per pair |
| dif_comp_o | output | 6 | Complement line level per pair |
| dif_hiz_o | output | 6 | High-impedance flag per pair |

## Verification
The assertions check several properties on every falling clock edge. An unlocked PLL or a cleared register enable must leave the run state off by the next falling edge. A running pair must present true high and complement low at the end of the clock high phase. The hiz flag must never appear with a driven level, and code 10 must park the pair high/low. The bench scenarios cover what a single-cycle property cannot show. These are the number of rising edges between a pin change and the start or stop of a pair, the pin sense under both polarity settings, all four parked states sampled in both clock phases, and the absence of any rising edge on the true line during the low phase.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;

    typedef enum logic [1:0] {
        PARK_LOW_LOW  = 2'b00,
        PARK_HIZ      = 2'b01,
        PARK_HIGH_LOW = 2'b10,
        PARK_LOW_HIGH = 2'b11
    } park_code_e;

    typedef struct packed {
        logic t;
        logic c;
        logic z;
    } pair_drive_t;

    typedef struct packed {
        logic run;
    } gate_state_t;

    function automatic pair_drive_t park_levels(park_code_e code);
        pair_drive_t lv;
        lv = '0;
        unique case (code)
            PARK_LOW_LOW:  lv = '{t: 1'b0, c: 1'b0, z: 1'b0};
            PARK_HIZ:      lv = '{t: 1'b0, c: 1'b0, z: 1'b1};
            PARK_HIGH_LOW: lv = '{t: 1'b1, c: 1'b0, z: 1'b0};
            PARK_LOW_HIGH: lv = '{t: 1'b0, c: 1'b1, z: 1'b0};
            default:       lv = '0;
        endcase
        return lv;
    endfunction

endpackage

// File: rtl/pin_sync.sv
`timescale 1ns/1ps
module pin_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[LAST];

endmodule

// File: rtl/pair_gate.sv
`timescale 1ns/1ps
module pair_gate
    import clkgate_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       enable_i,
    input  park_code_e park_i,
    output logic       true_o,
    output logic       comp_o,
    output logic       hiz_o,
    output logic       run_o
);
    gate_state_t state_d, state_q;
    pair_drive_t parked;

    always_comb begin
        state_d     = state_q;
        state_d.run = enable_i;
    end

    // run flag moves on the falling edge, so gating changes only while clk is low
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        parked = park_levels(park_i);
        if (state_q.run) begin
            true_o = clk_i;
            comp_o = ~clk_i;
            hiz_o  = 1'b0;
        end else begin
            true_o = parked.t;
            comp_o = parked.c;
            hiz_o  = parked.z;
        end
    end

    assign run_o = state_q.run;

    // R3 outcome: a dropped enable leaves the pair stopped after the next falling edge
    assert_enable_low_stops_R3: assert property (@(negedge clk_i) disable iff (!rst_ni)
        !enable_i |=> !run_o);

    // R5: a pair that ran through the high phase shows true high, complement low
    assert_running_levels_R5: assert property (@(negedge clk_i) disable iff (!rst_ni)
        run_o |-> (true_o && !comp_o && !hiz_o));

    // R6: tristate flag never coexists with a driven high level
    assert_hiz_undriven_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
        hiz_o |-> (!true_o && !comp_o));

    // R6: code 10 parks the pair high/low
    assert_park_high_low_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (!run_o && park_i == PARK_HIGH_LOW) |-> (true_o && !comp_o && !hiz_o));

endmodule

// File: rtl/clkout_gate_ctrl.sv
`timescale 1ns/1ps
module clkout_gate_ctrl
    import clkgate_pkg::*;
#(
    parameter int NUM_PAIRS   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk_out_i,
    input  logic                 rst_ni,
    input  logic                 pll_locked_i,
    input  logic [NUM_PAIRS-1:0] oe_pin_i,
    input  logic [NUM_PAIRS-1:0] oe_pol_i,
    input  logic [NUM_PAIRS-1:0] oe_reg_i,
    input  logic [1:0]           stop_code_i,
    output logic [NUM_PAIRS-1:0] dif_true_o,
    output logic [NUM_PAIRS-1:0] dif_comp_o,
    output logic [NUM_PAIRS-1:0] dif_hiz_o
);
    localparam int PW = NUM_PAIRS;

    logic [PW-1:0] pin_sync;
    logic [PW-1:0] want_run;
    logic [PW-1:0] run_vec;
    park_code_e    park_code;

    pin_sync #(
        .WIDTH  (PW),
        .STAGES (SYNC_STAGES)
    ) u_pin_sync (
        .clk_i   (clk_out_i),
        .rst_ni  (rst_ni),
        .async_i (oe_pin_i),
        .sync_o  (pin_sync)
    );

    always_comb begin
        park_code = park_code_e'(stop_code_i);
        for (int i = 0; i < PW; i++) begin
            // pin matches its programmed sense, register allows it, PLL is locked
            want_run[i] = pll_locked_i & oe_reg_i[i] & ~(pin_sync[i] ^ oe_pol_i[i]);
        end
    end

    for (genvar g = 0; g < PW; g++) begin : g_pair
        pair_gate u_gate (
            .clk_i    (clk_out_i),
            .rst_ni   (rst_ni),
            .enable_i (want_run[g]),
            .park_i   (park_code),
            .true_o   (dif_true_o[g]),
            .comp_o   (dif_comp_o[g]),
            .hiz_o    (dif_hiz_o[g]),
            .run_o    (run_vec[g])
        );
    end

    // R4: no pair may be running one falling edge after lock is seen low
    assert_unlocked_blocks_R4: assert property (@(negedge clk_out_i) disable iff (!rst_ni)
        !pll_locked_i |=> (run_vec == '0));

    // R3: cleared register enable silences the pair at the top level too
    assert_reg_override_R3: assert property (@(negedge clk_out_i) disable iff (!rst_ni)
        (oe_reg_i == '0) |=> (run_vec == '0));

endmodule

// File: tb/tb_clkout_gate_ctrl.sv
`timescale 1ns/1ps
module tb_clkout_gate_ctrl;

    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         pll_locked;
    logic [N-1:0] oe_pin, oe_pol, oe_reg;
    logic [1:0]   stop_code;
    logic [N-1:0] dif_true, dif_comp, dif_hiz;

    int checks = 0;
    int fails  = 0;
    int glitches = 0;
    logic mon_en = 1'b0;
    logic [N-1:0] prev_true = '0;

    always #2.5 clk = ~clk;

    clkout_gate_ctrl #(.NUM_PAIRS(N), .SYNC_STAGES(2)) dut (
        .clk_out_i    (clk),
        .rst_ni       (rst_n),
        .pll_locked_i (pll_locked),
        .oe_pin_i     (oe_pin),
        .oe_pol_i     (oe_pol),
        .oe_reg_i     (oe_reg),
        .stop_code_i  (stop_code),
        .dif_true_o   (dif_true),
        .dif_comp_o   (dif_comp),
        .dif_hiz_o    (dif_hiz)
    );

    // R9 monitor: a rising true line during the low phase is a runt
    always @(dif_true) begin
        for (int i = 0; i < N; i++) begin
            if (mon_en && dif_true[i] && !prev_true[i] && !clk) glitches++;
        end
        prev_true = dif_true;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic settle(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        #1;
    endtask

    // expected {t,c,z} per phase for pairs in run_mask; others parked per code
    task automatic check_pairs(input logic [N-1:0] run_mask, input logic [1:0] code, input string tag);
        logic [N-1:0] pt, pc, pz;
        pt = {N{code == 2'b10}};
        pc = {N{code == 2'b11}};
        pz = {N{code == 2'b01}};
        @(posedge clk); #1.25;
        check(dif_true == ((run_mask) | (pt & ~run_mask)), {tag, " true high-phase"}, dif_true, (run_mask) | (pt & ~run_mask));
        check(dif_comp == (pc & ~run_mask), {tag, " comp high-phase"}, dif_comp, pc & ~run_mask);
        check(dif_hiz == (pz & ~run_mask), {tag, " hiz high-phase"}, dif_hiz, pz & ~run_mask);
        @(negedge clk); #1.25;
        check(dif_true == (pt & ~run_mask), {tag, " true low-phase"}, dif_true, pt & ~run_mask);
        check(dif_comp == (run_mask | (pc & ~run_mask)), {tag, " comp low-phase"}, dif_comp, run_mask | (pc & ~run_mask));
        check(dif_hiz == (pz & ~run_mask), {tag, " hiz low-phase"}, dif_hiz, pz & ~run_mask);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pll_locked = 1'b1; oe_pin = '0; oe_pol = '0; oe_reg = '1; stop_code = 2'b00;
        settle(4);
        check_pairs('0, 2'b00, "R10 reset");
        drive_edge();
        rst_n = 1'b1;
        pll_locked = 1'b0;
        settle(2);
    endtask

    task automatic t_pll_block();
        settle(4);
        check_pairs('0, 2'b00, "R4 unlocked");
        drive_edge(); pll_locked = 1'b1;
        settle(5);
        check_pairs('1, 2'b00, "R1 R5 locked default");
        drive_edge(); pll_locked = 1'b0;
        settle(3);
        check_pairs('0, 2'b00, "R4 lock lost");
        drive_edge(); pll_locked = 1'b1;
        settle(5);
    endtask

    task automatic t_pin_sense();
        drive_edge(); oe_pin = 6'b001001;
        settle(5);
        check_pairs(6'b110110, 2'b00, "R1 pins high disable");
        drive_edge(); oe_pol = 6'b000101; oe_pin = 6'b000100;
        settle(5);
        check_pairs(6'b111110, 2'b00, "R2 polarity one");
        drive_edge(); oe_pin = 6'b000000;
        settle(5);
        check_pairs(6'b111010, 2'b00, "R2 polarity one pin low");
        drive_edge(); oe_pol = '0;
        settle(5);
        check_pairs('1, 2'b00, "R1 restore");
    endtask

    task automatic t_reg_override();
        drive_edge(); oe_reg = 6'b101111;
        settle(3);
        check_pairs(6'b101111, 2'b00, "R3 reg clears pair4");
        drive_edge(); oe_pol[4] = 1'b1; oe_pin[4] = 1'b1;
        settle(5);
        check_pairs(6'b101111, 2'b00, "R3 pin cannot override");
        drive_edge(); oe_reg = '1; oe_pol = '0; oe_pin = '0;
        settle(5);
    endtask

    task automatic t_latency(input int idx);
        int first;
        drive_edge(); oe_pin[idx] = 1'b1;
        settle(6);
        first = 0;
        drive_edge(); oe_pin[idx] = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            @(posedge clk); #1.25;
            if (first == 0 && dif_true[idx]) first = k;
        end
        check(first >= 1 && first <= 3, "R7 start latency", first, 3);
        first = 0;
        drive_edge(); oe_pin[idx] = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(posedge clk); #1.25;
            if (first == 0 && !dif_true[idx]) first = k;
        end
        check(first >= 1 && first <= 3, "R8 stop latency", first, 3);
        drive_edge(); oe_pin[idx] = 1'b0;
        settle(5);
    endtask

    task automatic t_park_codes();
        mon_en = 1'b0;
        drive_edge(); oe_pin = 6'b100010;
        settle(5);
        for (int cd = 0; cd < 4; cd++) begin
            drive_edge(); stop_code = 2'(cd);
            settle(2);
            check_pairs(6'b011101, 2'(cd), "R6 park code");
        end
    endtask

    initial begin
        fork
            begin
                t_reset();
                mon_en = 1'b1;
                t_pll_block();
                t_pin_sense();
                t_reg_override();
                t_latency(0);
                t_latency(5);
                check(glitches == 0, "R9 no runt pulse", glitches, 0);
                t_park_codes();
            end
            begin
                repeat (20000) @(posedge clk);
                check(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule